// File: doc/BRIEF.md
# Multi-Function Output Port Controller

This block owns an eight-pin general-purpose output port that can also carry internal status signals. The host changes port bits one at a time. A set strobe with a mask raises the selected register bits and a clear strobe with a mask lowers them, so no read-modify-write of the whole byte is needed. In general-purpose mode each pin drives the complement of its register bit. After reset the register is all zeros, so every pin idles high.

A separate function-select register reroutes individual pins to status sources without touching the port register. Pins 0 and 1 can serve as active-low request-to-send lines. The serial channels may drop these automatically through a per-channel pulse input. Pin 2 can carry one of three channel A clocks. Pin 3 can carry the counter/timer output as an active-low open-drain signal, or one of two channel B clocks. Pins 4 to 7 can carry the four per-channel interrupt conditions as active-low open-drain outputs. These can be wired together outside the chip to share one request line.

Each pin reports its level on `pin_val` and its drive style on `pin_od`. When `pin_od` is 1, the pad pulls low only while `pin_val` is 0 and releases the line otherwise. The interrupt status logic, baud clocks, counter/timer and serial channels sit outside this block and feed it through plain inputs.

Top module: `outport_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it rises, the port register and the function-select register are zero, `pin_val` is 8'hFF and `pin_od` is 8'h00.
- R2: At the clock edge where `set_we` is 1, every register bit whose `set_mask` bit is 1 becomes 1. Bits whose mask bit is 0 keep their value unless a clear or a drop hits them.
- R3: At the clock edge where `clr_we` is 1, every register bit whose `clr_mask` bit is 1 becomes 0, unless the same bit is being set in that cycle. Other bits are unchanged.
- R4: When a set and a clear (or a request-to-send drop) hit the same bit in the same cycle, the bit ends up 1.
- R5: A pin in general-purpose mode drives `pin_val` = NOT register bit, with `pin_od` = 0.
- R6: A write with `cfg_we` loads `cfg_data` into the function-select register at that clock edge. The pins keep the old routing until that edge and follow the new routing right after it.
- R7: Function-select bit 0 (channel A) or bit 1 (channel B) puts pin 0 or pin 1 in request-to-send mode, where the pin drives NOT register bit, push-pull. A pulse on `rts_drop[0]` or `rts_drop[1]` clears that register bit at the next edge, but only while that pin is in request-to-send mode. Otherwise the pulse has no effect.
- R8: Function-select bits [3:2] route pin 2: 00 general purpose, 01 `txa_clk16`, 10 `txa_clk1`, 11 `rxa_clk1`. Clocks are driven push-pull and not inverted.
- R9: Function-select bits [5:4] route pin 3: 00 general purpose, 01 NOT `ct_out` open-drain, 10 `txb_clk1`, 11 `rxb_clk1` (clocks push-pull, not inverted).
- R10: Function-select bit 6 sets pin 4 = NOT `irq_src[0]` (receiver A, status bit 1) and pin 5 = NOT `irq_src[1]` (receiver B, status bit 5). Bit 7 sets pin 6 = NOT `irq_src[2]` (transmitter A, status bit 0) and pin 7 = NOT `irq_src[3]` (transmitter B, status bit 4). All four are open-drain.
- R11: Routed pins follow their status inputs in the same cycle, with no register in the path. Set and clear writes keep updating the register bit of a routed pin, and the new value appears as soon as the pin returns to general-purpose mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_we | input | 1 | Set strobe |
| set_mask | input | 8 | Bits to raise on a set strobe |
| clr_we | input | 1 | Clear strobe |
| clr_mask | input | 8 | Bits to lower on a clear strobe |
| cfg_we | input | 1 | Function-select write strobe |
| cfg_data | input | 8 | New function-select value |
| rts_drop | input | 2 | Per-channel automatic request-to-send drop pulse (bit 0 channel A) |
| txa_clk16 | input | 1 | Channel A transmit 16x clock |
| txa_clk1 | input | 1 | Channel A transmit 1x clock |
| rxa_clk1 | input | 1 | Channel A receive 1x clock |
| txb_clk1 | input | 1 | Channel B transmit 1x clock |
| rxb_clk1 | input | 1 | Channel B receive 1x clock |
| ct_out | input | 1 | Counter/timer output |
| irq_src | input | 4 | Interrupt conditions: receiver A, receiver B, transmitter A, transmitter B |
| pin_val | output | 8 | Level of each port pin |
| pin_od | output | 8 | 1 where the pin is open-drain |

## Verification
Register writes, request-to-send drops and function-select writes take one clock edge to show on the pins. The bench drives all three on a falling edge and checks at the next falling edge. It also checks a few of them one nanosecond after driving, to confirm that nothing moves before the edge. Status-routed pins have zero latency, so the bench checks them one nanosecond after changing the status inputs, within the same low phase. Expected pin words come from arithmetic on a model register and model function-select value that the bench keeps itself, across a sweep of all 256 function-select values and all 256 set and clear masks.

// File: rtl/outport_pkg.sv
package outport_pkg;

    localparam int PORT_W    = 8;
    localparam int CFG_W     = 8;
    localparam int SRC_W     = 3;
    localparam int CLK_SLOTS = 1 << SRC_W;

    typedef enum logic [2:0] {
        PIN_GPIO  = 3'd0,
        PIN_RTS   = 3'd1,
        PIN_CLK   = 3'd2,
        PIN_TIMER = 3'd3,
        PIN_IRQ   = 3'd4
    } pin_mode_e;

    typedef struct packed {
        pin_mode_e         mode;
        logic [SRC_W-1:0]  src;
    } pin_route_t;

    // clock bus slots
    localparam logic [SRC_W-1:0] CK_TXA16 = 3'd0;
    localparam logic [SRC_W-1:0] CK_TXA1  = 3'd1;
    localparam logic [SRC_W-1:0] CK_RXA1  = 3'd2;
    localparam logic [SRC_W-1:0] CK_TXB1  = 3'd3;
    localparam logic [SRC_W-1:0] CK_RXB1  = 3'd4;

    // interrupt source slots
    localparam logic [SRC_W-1:0] IQ_RXA = 3'd0;
    localparam logic [SRC_W-1:0] IQ_RXB = 3'd1;
    localparam logic [SRC_W-1:0] IQ_TXA = 3'd2;
    localparam logic [SRC_W-1:0] IQ_TXB = 3'd3;

endpackage

// File: rtl/outport_bits.sv
module outport_bits #(
    parameter int W = outport_pkg::PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic [W-1:0] set_mask,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] drop_mask,
    output logic [W-1:0] q
);

    logic [W-1:0] set_eff;
    logic [W-1:0] clr_eff;
    logic [W-1:0] q_nxt;

    // set is applied last so it wins over clear and drop
    always_comb begin
        set_eff = set_we ? set_mask : '0;
        clr_eff = (clr_we ? clr_mask : '0) | drop_mask;
        q_nxt   = (q & ~clr_eff) | set_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_nxt;
        end
    end

endmodule

// File: rtl/outport_route.sv
module outport_route
    import outport_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_data,
    output logic [CFG_W-1:0]     cfg_q,
    output pin_route_t [W-1:0]   route
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= cfg_data;
        end
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            route[i].mode = PIN_GPIO;
            route[i].src  = '0;
        end

        if (cfg_q[0]) route[0].mode = PIN_RTS;
        if (cfg_q[1]) route[1].mode = PIN_RTS;

        unique case (cfg_q[3:2])
            2'b00: begin end
            2'b01: route[2] = '{mode: PIN_CLK, src: CK_TXA16};
            2'b10: route[2] = '{mode: PIN_CLK, src: CK_TXA1};
            2'b11: route[2] = '{mode: PIN_CLK, src: CK_RXA1};
        endcase

        unique case (cfg_q[5:4])
            2'b00: begin end
            2'b01: route[3] = '{mode: PIN_TIMER, src: '0};
            2'b10: route[3] = '{mode: PIN_CLK, src: CK_TXB1};
            2'b11: route[3] = '{mode: PIN_CLK, src: CK_RXB1};
        endcase

        if (cfg_q[6]) begin
            route[4] = '{mode: PIN_IRQ, src: IQ_RXA};
            route[5] = '{mode: PIN_IRQ, src: IQ_RXB};
        end
        if (cfg_q[7]) begin
            route[6] = '{mode: PIN_IRQ, src: IQ_TXA};
            route[7] = '{mode: PIN_IRQ, src: IQ_TXB};
        end
    end

endmodule

// File: rtl/outport_pin.sv
module outport_pin
    import outport_pkg::*;
(
    input  pin_route_t            route,
    input  logic                  gp_bit,
    input  logic [CLK_SLOTS-1:0]  clk_bus,
    input  logic                  ct_out,
    input  logic [3:0]            irq_src,
    output logic                  val,
    output logic                  od
);

    always_comb begin
        val = 1'b1;
        od  = 1'b0;
        unique case (route.mode)
            PIN_GPIO, PIN_RTS: val = ~gp_bit;
            PIN_CLK:           val = clk_bus[route.src];
            PIN_TIMER: begin
                val = ~ct_out;
                od  = 1'b1;
            end
            PIN_IRQ: begin
                val = ~irq_src[route.src[1:0]];
                od  = 1'b1;
            end
            default: begin end
        endcase
    end

endmodule

// File: rtl/outport_ctrl.sv
module outport_ctrl
    import outport_pkg::*;
#(
    parameter int PORT_W = outport_pkg::PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic [PORT_W-1:0] set_mask,
    input  logic              clr_we,
    input  logic [PORT_W-1:0] clr_mask,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic [1:0]        rts_drop,
    input  logic              txa_clk16,
    input  logic              txa_clk1,
    input  logic              rxa_clk1,
    input  logic              txb_clk1,
    input  logic              rxb_clk1,
    input  logic              ct_out,
    input  logic [3:0]        irq_src,
    output logic [PORT_W-1:0] pin_val,
    output logic [PORT_W-1:0] pin_od
);

    localparam int CLK_USED = 5;

    logic [PORT_W-1:0]       port_q;
    logic [PORT_W-1:0]       drop_mask;
    logic [CFG_W-1:0]        cfg_q;
    pin_route_t [PORT_W-1:0] route;
    logic [CLK_SLOTS-1:0]    clk_bus;

    assign clk_bus = {{(CLK_SLOTS-CLK_USED){1'b0}},
                      rxb_clk1, txb_clk1, rxa_clk1, txa_clk1, txa_clk16};

    // automatic drop only acts on a pin in request-to-send mode
    always_comb begin
        drop_mask    = '0;
        drop_mask[0] = rts_drop[0] && (route[0].mode == PIN_RTS);
        drop_mask[1] = rts_drop[1] && (route[1].mode == PIN_RTS);
    end

    outport_route #(.W(PORT_W)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_data (cfg_data),
        .cfg_q    (cfg_q),
        .route    (route)
    );

    outport_bits #(.W(PORT_W)) u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_we    (set_we),
        .set_mask  (set_mask),
        .clr_we    (clr_we),
        .clr_mask  (clr_mask),
        .drop_mask (drop_mask),
        .q         (port_q)
    );

    for (genvar g = 0; g < PORT_W; g++) begin : g_pin
        outport_pin u_pin (
            .route   (route[g]),
            .gp_bit  (port_q[g]),
            .clk_bus (clk_bus),
            .ct_out  (ct_out),
            .irq_src (irq_src),
            .val     (pin_val[g]),
            .od      (pin_od[g])
        );
    end

endmodule

// File: rtl/outport_ctrl_sva.sv
module outport_ctrl_sva #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         set_we,
    input logic [W-1:0] set_mask,
    input logic         clr_we,
    input logic [W-1:0] clr_mask,
    input logic         cfg_we,
    input logic [7:0]   cfg_data,
    input logic [1:0]   rts_drop,
    input logic [3:0]   irq_src,
    input logic [W-1:0] port_q,
    input logic [7:0]   cfg_q,
    input logic [W-1:0] pin_val,
    input logic [W-1:0] pin_od
);

    a_r1_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_val == {W{1'b1}} && pin_od == {W{1'b0}}));

    // R2 and R4: set bits always land
    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((port_q & $past(set_mask)) == $past(set_mask)));

    a_r2_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we && rts_drop == 2'b00) |=> $stable(port_q));

    a_r3_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((port_q & $past(clr_mask) & ~$past(set_we ? set_mask : {W{1'b0}})) == {W{1'b0}}));

    a_r5_gp_top_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[7] |-> (pin_val[7:6] == ~port_q[7:6] && pin_od[7:6] == 2'b00));

    a_r6_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q == $past(cfg_data)));

    a_r7_rts_drop_a: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[0] && rts_drop[0] && !(set_we && set_mask[0])) |=> !port_q[0]);

    a_r10_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[6] |-> (pin_od[5:4] == 2'b11 && pin_val[4] == !irq_src[0] && pin_val[5] == !irq_src[1]));

    a_r10_tx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[7] |-> (pin_od[7:6] == 2'b11 && pin_val[6] == !irq_src[2] && pin_val[7] == !irq_src[3]));

endmodule

bind outport_ctrl outport_ctrl_sva #(.W(PORT_W)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we   (set_we),
    .set_mask (set_mask),
    .clr_we   (clr_we),
    .clr_mask (clr_mask),
    .cfg_we   (cfg_we),
    .cfg_data (cfg_data),
    .rts_drop (rts_drop),
    .irq_src  (irq_src),
    .port_q   (port_q),
    .cfg_q    (cfg_q),
    .pin_val  (pin_val),
    .pin_od   (pin_od)
);

// File: tb/tb_outport_ctrl.sv
`timescale 1ns/1ps
module tb_outport_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       set_we, clr_we, cfg_we;
    logic [7:0] set_mask, clr_mask, cfg_data;
    logic [1:0] rts_drop;
    logic       txa_clk16, txa_clk1, rxa_clk1, txb_clk1, rxb_clk1, ct_out;
    logic [3:0] irq_src;
    logic [7:0] pin_val, pin_od;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [7:0] mq;
    logic [7:0] mc;
    logic [9:0] ms;

    always #2.5 clk = ~clk;

    outport_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .set_we(set_we), .set_mask(set_mask),
        .clr_we(clr_we), .clr_mask(clr_mask),
        .cfg_we(cfg_we), .cfg_data(cfg_data),
        .rts_drop(rts_drop),
        .txa_clk16(txa_clk16), .txa_clk1(txa_clk1), .rxa_clk1(rxa_clk1),
        .txb_clk1(txb_clk1), .rxb_clk1(rxb_clk1), .ct_out(ct_out),
        .irq_src(irq_src),
        .pin_val(pin_val), .pin_od(pin_od)
    );

    // expected {od, val} from register, function select and status word
    // s: [0] txa16 [1] txa1 [2] rxa1 [3] txb1 [4] rxb1 [5] timer [9:6] irq
    function automatic logic [15:0] model(logic [7:0] q, logic [7:0] c, logic [9:0] s);
        logic [7:0] v;
        logic [7:0] o;
        v = ~q;
        o = 8'h00;
        case (c[3:2])
            2'd1: v[2] = s[0];
            2'd2: v[2] = s[1];
            2'd3: v[2] = s[2];
            default: begin end
        endcase
        case (c[5:4])
            2'd1: begin v[3] = ~s[5]; o[3] = 1'b1; end
            2'd2: v[3] = s[3];
            2'd3: v[3] = s[4];
            default: begin end
        endcase
        if (c[6]) begin v[4] = ~s[6]; v[5] = ~s[7]; o[5:4] = 2'b11; end
        if (c[7]) begin v[6] = ~s[8]; v[7] = ~s[9]; o[7:6] = 2'b11; end
        return {o, v};
    endfunction

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got od/val %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_pins(string tag);
        chk(tag, {pin_od, pin_val}, model(mq, mc, ms));
    endtask

    task automatic drive_stat(logic [9:0] s);
        ms = s;
        {irq_src, ct_out, rxb_clk1, txb_clk1, rxa_clk1, txa_clk1, txa_clk16} = s;
    endtask

    // write on a falling edge, return at the next falling edge
    task automatic wr(logic se, logic [7:0] sm, logic ce, logic [7:0] cm);
        @(negedge clk);
        set_we = se; set_mask = sm; clr_we = ce; clr_mask = cm;
        @(negedge clk);
        set_we = 1'b0; clr_we = 1'b0;
        if (ce) mq = mq & ~cm;
        if (se) mq = mq | sm;
    endtask

    task automatic wcfg(logic [7:0] c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_data = c;
        @(negedge clk);
        cfg_we = 1'b0;
        mc = c;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [9:0] pats [4];
        pats[0] = 10'h000; pats[1] = 10'h3FF; pats[2] = 10'h155; pats[3] = 10'h2AA;

        rst_n = 1'b0;
        set_we = 0; clr_we = 0; cfg_we = 0;
        set_mask = 0; clr_mask = 0; cfg_data = 0; rts_drop = 0;
        mq = 8'h00; mc = 8'h00;
        drive_stat(10'h000);
        repeat (3) @(negedge clk);
        chk("R1 in reset", {pin_od, pin_val}, 16'h00FF);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {pin_od, pin_val}, 16'h00FF);

        // R2 and R5: set sweep on a preloaded register
        for (int m = 0; m < 256; m++) begin
            wr(0, 8'h00, 1, 8'hFF);
            wr(1, 8'h5A, 0, 8'h00);
            wr(1, 8'(m), 0, 8'h00);
            chk("R2 R5 set sweep", {pin_od, pin_val}, {8'h00, ~(8'h5A | 8'(m))});
        end

        // R3: clear sweep
        for (int m = 0; m < 256; m++) begin
            wr(0, 8'h00, 1, 8'hFF);
            wr(1, 8'hA5, 0, 8'h00);
            wr(0, 8'h00, 1, 8'(m));
            chk("R3 clear sweep", {pin_od, pin_val}, {8'h00, ~(8'hA5 & ~8'(m))});
        end

        // R4: simultaneous set and clear
        for (int k = 0; k < 64; k++) begin
            logic [7:0] a, b;
            a = 8'(k * 37);
            b = 8'(k * 91 + 3);
            wr(0, 8'h00, 1, 8'hFF);
            wr(1, 8'h3C, 0, 8'h00);
            wr(1, a, 1, b);
            chk("R4 set wins", {pin_od, pin_val}, {8'h00, ~((8'h3C & ~b) | a)});
        end

        // R8 R9 R10 R11: every function-select value under four status words
        wr(0, 8'h00, 1, 8'hFF);
        wr(1, 8'hA5, 0, 8'h00);
        for (int c = 0; c < 256; c++) begin
            wcfg(8'(c));
            for (int p = 0; p < 4; p++) begin
                drive_stat(pats[p]);
                #1;
                chk_pins("R8 R9 R10 R11 routing");
            end
        end

        // R6: old routing before the edge, new routing after
        drive_stat(10'h155);
        @(negedge clk);
        cfg_we = 1'b1; cfg_data = 8'h00;
        #1;
        chk_pins("R6 before edge");
        @(negedge clk);
        cfg_we = 1'b0;
        mc = 8'h00;
        chk_pins("R6 after edge");

        // R7: request-to-send, channel A
        drive_stat(10'h000);
        wcfg(8'h01);
        wr(0, 8'h00, 1, 8'hFF);
        wr(1, 8'h01, 0, 8'h00);
        chk_pins("R7 rts A active");
        @(negedge clk);
        rts_drop = 2'b01;
        #1;
        chk_pins("R7 drop before edge");
        @(negedge clk);
        rts_drop = 2'b00;
        mq[0] = 1'b0;
        chk_pins("R7 drop A clears");
        @(negedge clk);
        rts_drop = 2'b01; set_we = 1'b1; set_mask = 8'h01;
        @(negedge clk);
        rts_drop = 2'b00; set_we = 1'b0;
        mq[0] = 1'b1;
        chk_pins("R7 R4 set beats drop");
        wcfg(8'h00);
        @(negedge clk);
        rts_drop = 2'b01;
        @(negedge clk);
        rts_drop = 2'b00;
        chk_pins("R7 drop ignored in gp mode");

        // R7: channel B
        wcfg(8'h02);
        wr(1, 8'h02, 0, 8'h00);
        @(negedge clk);
        rts_drop = 2'b10;
        @(negedge clk);
        rts_drop = 2'b00;
        mq[1] = 1'b0;
        chk_pins("R7 drop B clears");
        wcfg(8'h00);
        wr(1, 8'h02, 0, 8'h00);
        @(negedge clk);
        rts_drop = 2'b10;
        @(negedge clk);
        rts_drop = 2'b00;
        chk_pins("R7 drop B ignored in gp mode");

        // R11: writes to a routed pin surface when it returns to gp
        wcfg(8'h40);
        wr(0, 8'h00, 1, 8'h30);
        wr(1, 8'h30, 0, 8'h00);
        chk_pins("R11 routed pin hides register");
        wcfg(8'h00);
        chk_pins("R11 register shows after return");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule